// File: doc/BRIEF.md
# Amplifier Control I2C Target

This block lets a host processor set the operating mode of a stereo speaker amplifier over a two-wire I2C bus. It samples SCL and SDA with the system clock through synchronizers and finds START and STOP conditions on the sampled lines. It answers only to its own 7-bit device address and holds three 8-bit control registers. It drives the amplifier control pins straight from those registers. SDA is driven as an open-drain enable: when `sda_oe` is high, the pad pulls the line low.

A write frame carries the address byte with R/W = 0, then a sub-address byte, then one or more data bytes. Data bytes after the first go to the next register in turn. A read frame carries the address byte with R/W = 1. The block then sends register 0, register 1 and register 2 in that order, with no sub-address phase. Register 0 sets the gain step, AGC enable, speaker-save mute and standby. Register 1 sets the AGC attack, recovery and on-level codes. Register 2 is a test register that software keeps at zero. The system clock must run at least 8 times faster than SCL.

Top module: `amp_ctl_i2c`

## Requirements
- R1: After reset, all three registers hold 0x00. This gives `gain_hi`=0, `agc_on`=0, `spk_mute`=1, `stby`=1, all codes 0, and `sda_oe`=0.
- R2: The block acknowledges address byte 0xB6 (write) and 0xB7 (read). Any other address byte gets no acknowledge, and the rest of that frame up to the next START changes no register and never drives SDA.
- R3: In register 0, bit 7 drives `gain_hi` (1 = +26 dB step, 0 = +20 dB step) and bit 3 drives `agc_on`. A 0 in bit 2 gives `spk_mute`=1, and a 0 in bit 1 gives `stby`=1.
- R4: In register 1, bits 1:0 drive `atk_code`, bits 4:2 drive `rec_code` and bits 7:5 drive `lvl_code`.
- R5: In a write frame, the first data byte goes to the register selected by the sub-address. Each further data byte goes to the next register index.
- R6: Only bits 3:0 of the sub-address byte select the register. Bits 7:4 have no effect.
- R7: The sub-address byte is always acknowledged. A data byte aimed at an index of 3 or more gets no acknowledge and changes no register.
- R8: A read frame returns register 0, then 1, then 2, MSB first. If the master acknowledges after register 2, the next byte sent is register 0 again.
- R9: A master NACK after a read byte ends the transfer. SDA is not driven again until the next START.
- R10: `sda_oe` changes only while SCL is low, and it is low after a STOP.
- R11: A repeated START restarts address decoding, so a write frame can turn into a read frame without a STOP in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| gain_hi | output | 1 | 1 selects the +26 dB gain step |
| agc_on | output | 1 | AGC enable |
| spk_mute | output | 1 | Speaker-save mute active |
| stby | output | 1 | Standby active |
| atk_code | output | 2 | AGC attack-time code |
| rec_code | output | 3 | AGC recovery-time code |
| lvl_code | output | 3 | AGC on-level code |

## Verification
Random write frames use a random sub-address, random upper-nibble noise and 1 to 3 data bytes. Each frame is followed by a full read-back, which shows whether auto-increment, nibble masking and out-of-range refusal agree with a bench model of the registers. Directed frames cover cases the random mix rarely produces. A foreign address followed by data separates "ignored" from "written". A four-byte read separates wrap-around from a stuck pointer. A NACK followed by extra clocks shows whether SDA is truly released. A repeated START after a sub-address shows that reads ignore the earlier pointer.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;

    localparam int BYTE_W   = 8;
    localparam int SUB_W    = 4;
    localparam int CNT_W    = 4;

    localparam int GAIN_BIT = 7;
    localparam int AGC_BIT  = 3;
    localparam int SAVE_BIT = 2;
    localparam int STBY_BIT = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } link_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic       gain_hi;
        logic       agc_on;
        logic       spk_mute;
        logic       stby;
        logic [1:0] atk;
        logic [2:0] rec;
        logic [2:0] lvl;
    } amp_cfg_t;

    function automatic amp_cfg_t decode_cfg(input logic [BYTE_W-1:0] mode_r,
                                            input logic [BYTE_W-1:0] agc_r);
        amp_cfg_t c;
        c.gain_hi  = mode_r[GAIN_BIT];
        c.agc_on   = mode_r[AGC_BIT];
        c.spk_mute = ~mode_r[SAVE_BIT];
        c.stby     = ~mode_r[STBY_BIT];
        c.atk      = agc_r[1:0];
        c.rec      = agc_r[4:2];
        c.lvl      = agc_r[7:5];
        return c;
    endfunction

endpackage

// File: rtl/amp_ctl_sync.sv
module amp_ctl_sync
    import amp_ctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LINES = 2;
    localparam int SCL_L = 1;
    localparam int SDA_L = 0;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now;
    logic [LINES-1:0] last;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign now[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) last <= '1;
        else     last <= now;
    end

    always_comb begin
        evt.scl_rise = now[SCL_L] & ~last[SCL_L];
        evt.scl_fall = ~now[SCL_L] & last[SCL_L];
        evt.start    = now[SCL_L] & last[SCL_L] & last[SDA_L] & ~now[SDA_L];
        evt.stop     = now[SCL_L] & last[SCL_L] & ~last[SDA_L] & now[SDA_L];
        evt.sda      = now[SDA_L];
    end

endmodule

// File: rtl/amp_ctl_regs.sv
module amp_ctl_regs
    import amp_ctl_pkg::*;
#(
    parameter int NUM_REGS = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [SUB_W-1:0]                   wr_idx,
    input  logic [BYTE_W-1:0]                  wr_data,
    output logic [NUM_REGS-1:0][BYTE_W-1:0]    bank,
    output amp_cfg_t                           cfg
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                bank[g] <= '0;
            else if (wr_en && wr_idx == SUB_W'(g))  bank[g] <= wr_data;
        end
    end

    assign cfg = decode_cfg(bank[0], bank[1]);

endmodule

// File: rtl/amp_ctl_fsm.sv
module amp_ctl_fsm
    import amp_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5B,
    parameter int         NUM_REGS = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  bus_evt_t                        evt,
    input  logic [NUM_REGS-1:0][BYTE_W-1:0] bank,
    output logic                            sda_oe,
    output logic                            wr_en,
    output logic [SUB_W-1:0]                wr_idx,
    output logic [BYTE_W-1:0]               wr_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LASTB = CNT_W'(BYTE_W - 1);

    link_state_e         state;
    logic [CNT_W-1:0]    cnt;
    logic [BYTE_W-1:0]   shreg;
    logic                rw;
    logic [SUB_W-1:0]    ptr;
    logic [IDX_W-1:0]    rd_idx;
    logic [IDX_W-1:0]    next_idx;

    assign next_idx = (rd_idx == IDX_W'(NUM_REGS - 1)) ? '0 : rd_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            sda_oe  <= 1'b0;
            rw      <= 1'b0;
            ptr     <= '0;
            rd_idx  <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (evt.scl_rise && cnt != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end else if (state == ST_SUB) begin
                                ptr    <= shreg[SUB_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_SUB_ACK;
                            end else begin
                                if (ptr < SUB_W'(NUM_REGS)) begin
                                    sda_oe  <= 1'b1;
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 1'b1;
                                end
                                state <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            if (rw) begin
                                rd_idx <= '0;
                                shreg  <= bank[0];
                                sda_oe <= ~bank[0][BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_SUB;
                            end
                        end
                    end
                    ST_SUB_ACK, ST_WDATA_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_fall) begin
                            if (cnt == LASTB) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise && evt.sda) begin
                            state <= ST_IDLE;
                        end else if (evt.scl_fall) begin
                            rd_idx <= next_idx;
                            shreg  <= bank[next_idx];
                            sda_oe <= ~bank[next_idx][BYTE_W-1];
                            state  <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/amp_ctl_i2c.sv
module amp_ctl_i2c
    import amp_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5B,
    parameter int         NUM_REGS    = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       gain_hi,
    output logic       agc_on,
    output logic       spk_mute,
    output logic       stby,
    output logic [1:0] atk_code,
    output logic [2:0] rec_code,
    output logic [2:0] lvl_code
);
    bus_evt_t                        bus_evt;
    logic [NUM_REGS-1:0][BYTE_W-1:0] bank;
    amp_cfg_t                        cfg;
    logic                            wr_en;
    logic [SUB_W-1:0]                wr_idx;
    logic [BYTE_W-1:0]               wr_data;
    logic                            stop_seen;

    assign stop_seen = bus_evt.stop;

    amp_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (bus_evt)
    );

    amp_ctl_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (bus_evt),
        .bank    (bank),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    amp_ctl_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bank    (bank),
        .cfg     (cfg)
    );

    assign gain_hi  = cfg.gain_hi;
    assign agc_on   = cfg.agc_on;
    assign spk_mute = cfg.spk_mute;
    assign stby     = cfg.stby;
    assign atk_code = cfg.atk;
    assign rec_code = cfg.rec;
    assign lvl_code = cfg.lvl;

endmodule

// File: rtl/amp_ctl_chk.sv
module amp_ctl_chk #(
    parameter int NUM_REGS = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [3:0] wr_idx,
    input logic       stop_seen,
    input logic [11:0] pins
);
    AST_RESET_SAFE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pins[9] && pins[8] && !pins[10] && !pins[11] && pins[7:0] == 8'h00)); // R1

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(pins)); // R2

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < 4'(NUM_REGS))); // R7

    AST_SDA_EDGE_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_i); // R10

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_oe); // R10

endmodule

bind amp_ctl_i2c amp_ctl_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .stop_seen (stop_seen),
    .pins      ({gain_hi, agc_on, spk_mute, stby, atk_code, rec_code, lvl_code})
);

// File: tb/amp_ctl_i2c_tb.sv
`timescale 1ns/1ps
module amp_ctl_i2c_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic scl_m, sda_m;
    logic sda_oe, gain_hi, agc_on, spk_mute, stby;
    logic [1:0] atk_code;
    logic [2:0] rec_code, lvl_code;
    logic sda_line;
    assign sda_line = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [3];

    amp_ctl_i2c u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .gain_hi(gain_hi), .agc_on(agc_on), .spk_mute(spk_mute), .stby(stby),
        .atk_code(atk_code), .rec_code(rec_code), .lvl_code(lvl_code)
    );

    function automatic logic [11:0] exp_pins(input logic [7:0] r0, input logic [7:0] r1);
        return {r0[7], r0[3], ~r0[2], ~r0[1], r1[1:0], r1[4:2], r1[7:5]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0; hold();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); b = sda_line; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic rd_byte(input logic m_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        send_bit(~m_ack);
    endtask

    task automatic chk_pins(input string req);
        chk(req, {20'h0, gain_hi, agc_on, spk_mute, stby, atk_code, rec_code, lvl_code},
            {20'h0, exp_pins(model[0], model[1])});
    endtask

    // Write frame; updates the model and checks every acknowledge.
    task automatic write_frame(input string req, input logic [7:0] sub, input int n, input logic [7:0] d0,
                               input logic [7:0] d1, input logic [7:0] d2);
        logic ack;
        logic [7:0] dv;
        int p;
        bus_start();
        wr_byte(8'hB6, ack); chk({req, " addr ack"}, ack, 1);
        wr_byte(sub, ack);   chk({req, " sub ack"}, ack, 1);
        p = int'(sub[3:0]);
        for (int k = 0; k < n; k++) begin
            dv = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            wr_byte(dv, ack);
            chk({req, " data ack"}, ack, (p < 3) ? 1 : 0);
            if (p < 3) begin model[p] = dv; p++; end
        end
        bus_stop();
    endtask

    task automatic read_check(input string req, input int n);
        logic ack;
        logic [7:0] d;
        bus_start();
        wr_byte(8'hB7, ack); chk({req, " read addr ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, d);
            chk({req, " read data"}, d, model[k % 3]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic ack, b;
        logic [7:0] d;
        logic [7:0] sub;
        logic [7:0] r [3];
        int n;
        void'($urandom(32'd20240611));
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
        for (int i = 0; i < 3; i++) model[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk_pins("R1 reset pins");
        chk("R1 sda released", sda_oe, 0);
        read_check("R1", 3);

        // R3 register 0 decode
        write_frame("R3", 8'h00, 1, 8'h8E, 8'h00, 8'h00);
        chk_pins("R3 mode decode");
        write_frame("R3", 8'h00, 1, 8'h04, 8'h00, 8'h00);
        chk_pins("R3 mode decode b");

        // R4 register 1 decode
        write_frame("R4", 8'h01, 1, 8'hB5, 8'h00, 8'h00);
        chk_pins("R4 agc code decode");

        // R5 auto-increment across all three
        write_frame("R5", 8'h00, 3, 8'h0A, 8'h6C, 8'h00);
        chk_pins("R5 auto increment pins");
        read_check("R5", 3);

        // R6 upper nibble of sub-address ignored
        write_frame("R6", 8'h71, 1, 8'h23, 8'h00, 8'h00);
        chk_pins("R6 nibble masked");

        // R7 out-of-range sub-addresses
        write_frame("R7", 8'h05, 1, 8'hFF, 8'h00, 8'h00);
        chk_pins("R7 no change");
        write_frame("R7", 8'h02, 2, 8'h00, 8'hFF, 8'h00);
        read_check("R7", 3);

        // R2 foreign addresses are ignored
        bus_start();
        wr_byte(8'hA6, ack); chk("R2 foreign addr nack", ack, 0);
        wr_byte(8'h00, ack); chk("R2 ignored byte nack", ack, 0);
        wr_byte(8'h00, ack); chk("R2 ignored byte nack", ack, 0);
        bus_stop();
        chk_pins("R2 foreign frame no effect");
        bus_start();
        wr_byte(8'hB5, ack); chk("R2 foreign read nack", ack, 0);
        bus_stop();

        // R8 read wrap after register 2
        write_frame("R8", 8'h00, 3, 8'hCA, 8'h5D, 8'h00);
        read_check("R8 wrap", 4);

        // R9 NACK ends read, SDA stays released
        bus_start();
        wr_byte(8'hB7, ack); chk("R9 addr ack", ack, 1);
        rd_byte(1'b0, d); chk("R9 first byte", d, model[0]);
        d = 8'h00;
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        chk("R9 released after nack", d, 8'hFF);
        get_bit(b);
        bus_stop();
        chk("R10 sda released after stop", sda_oe, 0);

        // R11 repeated START switches to read
        bus_start();
        wr_byte(8'hB6, ack); chk("R11 addr ack", ack, 1);
        wr_byte(8'h02, ack); chk("R11 sub ack", ack, 1);
        bus_start();
        wr_byte(8'hB7, ack); chk("R11 restart ack", ack, 1);
        rd_byte(1'b0, d); chk("R11 read starts at reg0", d, model[0]);
        bus_stop();

        // Random write frames with read-back (R5, R6, R7, R8)
        for (int it = 0; it < 18; it++) begin
            sub = {4'($urandom_range(0, 15)), 4'($urandom_range(0, 4))};
            n = $urandom_range(1, 3);
            for (int i = 0; i < 3; i++) r[i] = 8'($urandom);
            write_frame("R5 random", sub, n, r[0], r[1], r[2]);
            chk_pins("R3 random pins");
            read_check("R8 random", 3);
        end

        chk("R10 final release", sda_oe, 0);
        summary();
        $finish;
    end

endmodule